// File: doc/BRIEF.md
# LCD Vertical Start and AC-Polarity Generator

This block makes the field-rate start pulse and the AC-drive polarity signal for an LCD panel. When an external vertical sync is present, the start pulse is placed at a selectable line offset from that sync. The offset can be two lines late, one line late, central, or one line early. When the sync goes missing, the block counts lines against a period chosen by the video mode. After a full period with no sync, it raises a no-signal flag and starts a free-running field cycle, so the panel keeps receiving alternating drive.

Both sync inputs are active low and sampled on the block clock. Every falling edge of the line sync counts as one line. In the modes that use a doubled line rate, that count is in doubled-rate lines. The polarity output toggles either on every line or once per emitted start pulse, under the control of one input pin.

Top module: `lcd_vtiming`

## Requirements
- R1: While reset is asserted and right after it, `vst`, `frp` and `noSignal` are all 0.
- R2: Only a falling edge (1 then 0 on consecutive clocks) of `hsyncN` counts a line, and only a falling edge of `vsyncN` counts as a field sync. Rising edges do nothing.
- R3: `vst` is a pulse one clock wide, registered one clock after the edge that triggers it. With `vpos` = 2'b10 (central), it follows the `vsyncN` falling edge.
- R4: With `vpos` = 2'b01, `vst` follows the first `hsyncN` fall after the field sync. With `vpos` = 2'b00, it follows the second such fall. Neither code pulses on the sync edge itself.
- R5: With `vpos` = 2'b11, `vst` follows the `hsyncN` fall that leaves one line before the next expected sync, using the line count of the previous field. That count is used only when it was measured between two sync edges. A field measured from a free-run wrap gives no early pulse.
- R6: With `auxLong` = 0, the free-run period depends on the mode decode. `hdSelN` = 0 selects HD, at 577 lines. Otherwise `altSel` = 1 selects the converted-HD mode, at 545 lines. Otherwise `stdSel` = 1 (NTSC, or NTSC wide when `wideSelN` = 0) gives 545 lines, and `stdSel` = 0 (PAL or PAL+) gives 641 lines.
- R7: With `auxLong` = 1, the free-run period is 769 lines in every mode.
- R8: When a full period of lines passes with no sync fall, `noSignal` rises together with a `vst` pulse. While `noSignal` is 1, `vst` pulses once every period lines and the `vpos` code is ignored.
- R9: The first sync fall clears `noSignal` and restarts the line count, so the next `vpos` placement counts from that edge.
- R10: With `lineFrp` = 1, `frp` toggles on every `hsyncN` fall.
- R11: With `lineFrp` = 0, `frp` toggles exactly with each `vst` pulse, including free-run pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncN | input | 1 | Line sync, active low |
| vsyncN | input | 1 | Field sync, active low |
| stdSel | input | 1 | 1: 60 Hz family, 0: 50 Hz family |
| wideSelN | input | 1 | 0: wide-screen variant of the family |
| hdSelN | input | 1 | 0: HD mode (overrides the others) |
| altSel | input | 1 | 1: converted-HD mode (when not HD) |
| auxLong | input | 1 | 1: long 769-line free-run period |
| lineFrp | input | 1 | 1: polarity per line, 0: per field |
| vpos | input | 2 | Start-pulse placement code |
| vst | output | 1 | Vertical start pulse |
| frp | output | 1 | AC-drive polarity |
| noSignal | output | 1 | Field sync missing |

## Verification
A wrong line count shows up within one field. It appears as a start pulse one or more lines away from its expected place, or as a free-run wrap on the wrong line. The bench checks every line of several complete free-run periods, so a one-line error in any period value fails on that line. A stale validity bit for the measured field length shows up as an early pulse in the first field after free-run ends. A polarity fault shows up on the very next line or pulse, because `frp` is compared after every line.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [2:0] {
    MODE_NTSC,
    MODE_NTSC_WIDE,
    MODE_PAL,
    MODE_PAL_PLUS,
    MODE_HD,
    MODE_MNDC
  } vmode_e;

  typedef enum logic [1:0] {
    VP_LATE2  = 2'b00,
    VP_LATE1  = 2'b01,
    VP_CENTER = 2'b10,
    VP_EARLY1 = 2'b11
  } vpos_e;

  // control -> datapath
  typedef struct packed {
    logic restart;
    logic step;
    logic capture;
  } cntCmd_t;

  // datapath -> control
  typedef struct packed {
    logic atLine0;
    logic atLine1;
    logic atEarly;
    logic atWrap;
  } cntFlags_t;

  function automatic vmode_e decodeMode(input logic stdSel, input logic wideSelN,
                                        input logic hdSelN, input logic altSel);
    vmode_e m;
    if (!hdSelN)      m = MODE_HD;
    else if (altSel)  m = MODE_MNDC;
    else if (stdSel)  m = wideSelN ? MODE_NTSC : MODE_NTSC_WIDE;
    else              m = wideSelN ? MODE_PAL : MODE_PAL_PLUS;
    return m;
  endfunction

endpackage

// File: rtl/vtg_count.sv
module vtg_count
  import vtg_pkg::*;
#(
  parameter int PERIOD_STD = 545,
  parameter int PERIOD_PAL = 641,
  parameter int PERIOD_HD  = 577,
  parameter int PERIOD_AUX = 769,
  parameter int CNT_W      = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  cntCmd_t   cmd,
  input  vmode_e    mode,
  input  logic      auxLong,
  output cntFlags_t flags
);

  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] lastLen;
  logic             lastValid;
  logic             sawSync;
  logic [CNT_W-1:0] periodSel;

  always_comb begin
    if (auxLong) periodSel = CNT_W'(PERIOD_AUX);
    else begin
      unique case (mode)
        MODE_PAL, MODE_PAL_PLUS: periodSel = CNT_W'(PERIOD_PAL);
        MODE_HD:                 periodSel = CNT_W'(PERIOD_HD);
        default:                 periodSel = CNT_W'(PERIOD_STD);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt   <= '0;
      lastLen   <= '0;
      lastValid <= 1'b0;
      sawSync   <= 1'b0;
    end else if (cmd.restart) begin
      lineCnt <= '0;
      if (cmd.capture) begin
        lastLen   <= lineCnt;
        lastValid <= sawSync;
        sawSync   <= 1'b1;
      end else begin
        sawSync <= 1'b0;
      end
    end else if (cmd.step) begin
      lineCnt <= lineCnt + CNT_W'(1);
    end
  end

  always_comb begin
    flags.atLine0 = (lineCnt == '0);
    flags.atLine1 = (lineCnt == CNT_W'(1));
    flags.atEarly = lastValid && (lastLen >= CNT_W'(2)) && (lineCnt == lastLen - CNT_W'(2));
    flags.atWrap  = (lineCnt == periodSel - CNT_W'(1));
  end

endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hsyncN,
  input  logic      vsyncN,
  input  logic      lineFrp,
  input  vpos_e     vpos,
  input  cntFlags_t flags,
  output cntCmd_t   cmd,
  output logic      vst,
  output logic      frp,
  output logic      noSignal
);

  logic vsPrev, hsPrev;
  logic vsFall, hsFall;
  logic fire, setNs, clrNs, frpFlip;

  assign vsFall = vsPrev & ~vsyncN;
  assign hsFall = hsPrev & ~hsyncN;

  always_comb begin
    cmd   = '0;
    fire  = 1'b0;
    setNs = 1'b0;
    clrNs = 1'b0;
    if (vsFall) begin
      cmd.restart = 1'b1;
      cmd.capture = 1'b1;
      clrNs       = 1'b1;
      fire        = (vpos == VP_CENTER);
    end else if (hsFall) begin
      if (flags.atWrap) begin
        cmd.restart = 1'b1;
        setNs       = 1'b1;
        fire        = 1'b1;
      end else begin
        cmd.step = 1'b1;
        if (!noSignal) begin
          unique case (vpos)
            VP_LATE1:  fire = flags.atLine0;
            VP_LATE2:  fire = flags.atLine1;
            VP_EARLY1: fire = flags.atEarly;
            default:   fire = 1'b0;
          endcase
        end
      end
    end
    frpFlip = lineFrp ? hsFall : fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsPrev   <= 1'b1;
      hsPrev   <= 1'b1;
      vst      <= 1'b0;
      frp      <= 1'b0;
      noSignal <= 1'b0;
    end else begin
      vsPrev <= vsyncN;
      hsPrev <= hsyncN;
      vst    <= fire;
      if (frpFlip) frp <= ~frp;
      if (clrNs)      noSignal <= 1'b0;
      else if (setNs) noSignal <= 1'b1;
    end
  end

endmodule

// File: rtl/lcd_vtiming.sv
module lcd_vtiming
  import vtg_pkg::*;
#(
  parameter int PERIOD_STD = 545,
  parameter int PERIOD_PAL = 641,
  parameter int PERIOD_HD  = 577,
  parameter int PERIOD_AUX = 769
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hsyncN,
  input  logic       vsyncN,
  input  logic       stdSel,
  input  logic       wideSelN,
  input  logic       hdSelN,
  input  logic       altSel,
  input  logic       auxLong,
  input  logic       lineFrp,
  input  logic [1:0] vpos,
  output logic       vst,
  output logic       frp,
  output logic       noSignal
);

  localparam int MAX_A  = (PERIOD_STD > PERIOD_PAL) ? PERIOD_STD : PERIOD_PAL;
  localparam int MAX_B  = (PERIOD_HD > PERIOD_AUX) ? PERIOD_HD : PERIOD_AUX;
  localparam int MAX_P  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_P + 1);

  cntCmd_t   cmd;
  cntFlags_t flags;
  vmode_e    mode;

  assign mode = decodeMode(stdSel, wideSelN, hdSelN, altSel);

  vtg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncN   (hsyncN),
    .vsyncN   (vsyncN),
    .lineFrp  (lineFrp),
    .vpos     (vpos_e'(vpos)),
    .flags    (flags),
    .cmd      (cmd),
    .vst      (vst),
    .frp      (frp),
    .noSignal (noSignal)
  );

  vtg_count #(
    .PERIOD_STD (PERIOD_STD),
    .PERIOD_PAL (PERIOD_PAL),
    .PERIOD_HD  (PERIOD_HD),
    .PERIOD_AUX (PERIOD_AUX),
    .CNT_W      (CNT_W)
  ) u_count (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .mode    (mode),
    .auxLong (auxLong),
    .flags   (flags)
  );

endmodule

// File: rtl/lcd_vtiming_chk.sv
module lcd_vtiming_chk #(
  parameter int FREE_MAX = 769
) (
  input logic clk,
  input logic rstN,
  input logic hsyncN,
  input logic vsyncN,
  input logic lineFrp,
  input logic vst,
  input logic frp,
  input logic noSignal
);

  logic        hsSeen, vsSeen;
  logic [11:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsSeen     <= 1'b1;
      vsSeen     <= 1'b1;
      sinceStart <= '0;
    end else begin
      hsSeen <= hsyncN;
      vsSeen <= vsyncN;
      if ((vsSeen && !vsyncN) || vst) sinceStart <= '0;
      else if (hsSeen && !hsyncN)     sinceStart <= sinceStart + 12'd1;
    end
  end

  a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noSignal) |-> vst);

  a_r9_sync_clears: assert property (@(posedge clk) disable iff (!rstN)
    ($past(vsyncN) && !vsyncN) |=> !noSignal);

  a_r10_line_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (lineFrp && $past(hsyncN) && !hsyncN) |=> (frp != $past(frp)));

  a_r11_field_toggle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!lineFrp) && (frp != $past(frp))) |-> vst);

  a_r7_period_bound: assert property (@(posedge clk) disable iff (!rstN)
    sinceStart <= 12'(FREE_MAX));

endmodule

bind lcd_vtiming lcd_vtiming_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hsyncN   (hsyncN),
  .vsyncN   (vsyncN),
  .lineFrp  (lineFrp),
  .vst      (vst),
  .frp      (frp),
  .noSignal (noSignal)
);

// File: tb/lcd_vtiming_tb.sv
`timescale 1ns/1ps
module lcd_vtiming_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncN = 1'b1, vsyncN = 1'b1;
  logic stdSel = 1'b1, wideSelN = 1'b1, hdSelN = 1'b1, altSel = 1'b0;
  logic auxLong = 1'b0, lineFrp = 1'b0;
  logic [1:0] vpos = 2'b10;
  logic vst, frp, noSignal;

  lcd_vtiming u_dut (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .vsyncN(vsyncN),
    .stdSel(stdSel), .wideSelN(wideSelN), .hdSelN(hdSelN), .altSel(altSel),
    .auxLong(auxLong), .lineFrp(lineFrp), .vpos(vpos),
    .vst(vst), .frp(frp), .noSignal(noSignal)
  );

  always #5 clk = ~clk;

  typedef struct {
    int    cyc;
    logic  vst;
    logic  frp;
    logic  ns;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t e;
  int   cyc = 0;
  int   nChecks = 0, nFails = 0;
  logic expFrp = 1'b0;
  logic expNs = 1'b0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations when their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      nChecks++;
      if (e.cyc != cyc || vst !== e.vst || frp !== e.frp || noSignal !== e.ns) begin
        nFails++;
        $display("FAIL %s cyc %0d: vst/frp/noSignal = %b%b%b expected %b%b%b",
                 e.tag, cyc, vst, frp, noSignal, e.vst, e.frp, e.ns);
      end
    end
  end

  task automatic push(input int at, input logic v, input string tag);
    exp_t x;
    x.cyc = at; x.vst = v; x.frp = expFrp; x.ns = expNs; x.tag = tag;
    q.push_back(x);
  endtask

  // field sync edge; fire = whether a start pulse is expected from it
  task automatic doVs(input bit fire, input string tag);
    @(negedge clk);
    vsyncN = 1'b0;
    expNs = 1'b0;
    if (fire && !lineFrp) expFrp = ~expFrp;
    push(cyc + 1, fire, tag);
    push(cyc + 2, 1'b0, tag);
    @(negedge clk);
    vsyncN = 1'b1;
  endtask

  // one line; fire = pulse expected, nsAfter = flag after this line
  task automatic doHs(input bit fire, input bit nsAfter, input string tag);
    @(negedge clk);
    hsyncN = 1'b0;
    expNs = nsAfter;
    if (lineFrp || fire) expFrp = ~expFrp;
    push(cyc + 1, fire, tag);
    push(cyc + 2, 1'b0, tag);
    @(negedge clk);
    hsyncN = 1'b1;
  endtask

  task automatic freeRun(input int n, input bit nsBefore, input string tag);
    for (int i = 0; i < n - 1; i++) doHs(1'b0, nsBefore, tag);
    doHs(1'b1, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (vst !== 1'b0 || frp !== 1'b0 || noSignal !== 1'b0) begin
      nFails++;
      $display("FAIL R1 in reset: %b%b%b expected 000", vst, frp, noSignal);
    end
    rstN = 1'b1;
    push(cyc + 1, 1'b0, "R1");
    repeat (2) @(negedge clk);

    // central placement, 60 Hz family, polarity per field
    vpos = 2'b10;
    doVs(1'b1, "R3");
    for (int i = 0; i < 4; i++) doHs(1'b0, 1'b0, "R2");
    doVs(1'b1, "R3");

    // one and two lines late
    vpos = 2'b01;
    doVs(1'b0, "R4");
    doHs(1'b1, 1'b0, "R4");
    for (int i = 0; i < 3; i++) doHs(1'b0, 1'b0, "R4");
    vpos = 2'b00;
    doVs(1'b0, "R4");
    doHs(1'b0, 1'b0, "R4");
    doHs(1'b1, 1'b0, "R4");
    doHs(1'b0, 1'b0, "R4");

    // one line early, previous field 3 lines
    vpos = 2'b11;
    doVs(1'b0, "R5");
    doHs(1'b0, 1'b0, "R5");
    doHs(1'b1, 1'b0, "R5");
    doHs(1'b0, 1'b0, "R5");
    doVs(1'b0, "R5");

    // free run, 60 Hz wide mode, then code ignored while no signal
    vpos = 2'b10;
    wideSelN = 1'b0;
    freeRun(545, 1'b0, "R6");
    vpos = 2'b01;
    freeRun(545, 1'b1, "R8");

    // sync returns: flag clears and count restarts
    doVs(1'b0, "R9");
    doHs(1'b1, 1'b0, "R9");

    // 50 Hz family with per-line polarity
    stdSel = 1'b0; wideSelN = 1'b1; lineFrp = 1'b1;
    doVs(1'b0, "R10");
    doHs(1'b1, 1'b0, "R10");
    for (int i = 0; i < 639; i++) doHs(1'b0, 1'b0, "R6");
    doHs(1'b1, 1'b1, "R10");
    lineFrp = 1'b0;

    // early placement must not use a field measured from a wrap
    vpos = 2'b11;
    for (int i = 0; i < 3; i++) doHs(1'b0, 1'b1, "R5");
    doVs(1'b0, "R5");
    for (int i = 0; i < 3; i++) doHs(1'b0, 1'b0, "R5");
    doVs(1'b0, "R5");
    doHs(1'b0, 1'b0, "R5");
    doHs(1'b1, 1'b0, "R5");
    doHs(1'b0, 1'b0, "R5");

    // HD period, long period, converted-HD period
    vpos = 2'b10;
    hdSelN = 1'b0;
    doVs(1'b1, "R11");
    freeRun(577, 1'b0, "R6");
    auxLong = 1'b1;
    doVs(1'b1, "R7");
    freeRun(769, 1'b0, "R7");
    auxLong = 1'b0; hdSelN = 1'b1; altSel = 1'b1;
    doVs(1'b1, "R11");
    freeRun(545, 1'b0, "R6");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL queue: %0d items left expected 0", q.size());
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule